// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed (two's-complement) operands of `WIDTH` bits over several clock cycles and returns the signed product of `2*WIDTH` bits. It uses radix-2 Booth recoding, so a negative multiplier needs no sign conversion before or after the run. A single register holds the partial product in its upper half and the multiplier in its lower half. A spare bit sits to the right of that register. In each cycle the block looks at the two lowest bits it is tracking. From that pair it adds the multiplicand into the upper half, subtracts it, or leaves the upper half alone. It then shifts the whole register right arithmetically.

Control is plain: the caller drives the operands and pulses `start`. `busy` stays high for the run, and `done` pulses once when the product is ready. The block has no back-pressure, and nothing is queued. While `busy` is high a new `start` is dropped without effect. In the cycle that `done` is high the block is already idle, so a new `start` in that cycle is accepted. The operands are captured only in the cycle a `start` is accepted. The result then stays on `product` until the next accepted `start`.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` seen while `busy` is 0 captures `mcand` and `mplier` and sets `busy` at the next clock edge.
- R3: `done` rises exactly `WIDTH` clock edges after the edge that captured the operands, stays high for a single cycle, and falls in the following cycle.
- R4: When `done` is high, `product` equals the signed product `mcand * mplier` in `2*WIDTH` bits. For example, with `WIDTH` = 8, the operands 2 and -3 give 16'hFFFA.
- R5: The extreme operands give exact results. For example, -128 times -128 gives 16'h4000, and -128 times 127 gives 16'hC080.
- R6: While `busy` is 0 and no `start` arrives, `product` does not change, whatever happens on the operand inputs.
- R7: A `start` that arrives while `busy` is 1 has no effect. The running product and the timing of `done` are both unchanged.
- R8: `busy` and `done` are never both high. `busy` falls in the same edge at which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply; taken only when idle |
| mcand | input | WIDTH | Signed multiplicand, sampled with an accepted start |
| mplier | input | WIDTH | Signed multiplier, sampled with an accepted start |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
Two events can meet in the same cycle. One is the completion of a run, when `done` pulses and `busy` falls. The other is a fresh `start` request. The bench drives `start` with new operands in the exact cycle `done` is seen. It checks that the second run is accepted, that it completes after another `WIDTH` edges, and that it gives the second product. Separately, the bench pulses `start` with different operands in the middle of a run. It judges that the request was dropped by the unchanged first product and the unchanged cycle count.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_KEEP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [1:0] pair,   // {current multiplier bit, bit to its right}
  output booth_op_e  op
);
  always_comb begin
    unique case (pair)
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_KEEP;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] upper,
  input  logic [WIDTH-1:0] mcand,
  input  booth_op_e        op,
  output logic [WIDTH:0]   sum
);
  localparam int EW = WIDTH + 1;
  logic [EW-1:0] up_x, mc_x;

  // sign-extend by one bit so -2^(WIDTH-1) cannot overflow
  assign up_x = {upper[WIDTH-1], upper};
  assign mc_x = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      OP_ADD:  sum = up_x + mc_x;
      OP_SUB:  sum = up_x - mc_x;
      default: sum = up_x;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] iter_q;

  assign load = start && !busy;
  assign step = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        iter_q <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        iter_q <= iter_q + 1'b1;
        if (iter_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R8
  AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_BUSY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && iter_q != LAST) |=> (busy && iter_q == $past(iter_q) + 1'b1)); // R7
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    acc_q;
  logic             xbit_q;
  logic [WIDTH-1:0] mc_q;
  logic             load, step;
  booth_op_e        op;
  logic [WIDTH:0]   sum;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .load (load),
    .step (step),
    .busy (busy),
    .done (done)
  );

  booth_recode u_rec (
    .pair({acc_q[0], xbit_q}),
    .op  (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_as (
    .upper(acc_q[PW-1:WIDTH]),
    .mcand(mc_q),
    .op   (op),
    .sum  (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      xbit_q <= 1'b0;
      mc_q   <= '0;
    end else if (load) begin
      acc_q  <= {{WIDTH{1'b0}}, mplier};
      xbit_q <= 1'b0;
      mc_q   <= mcand;
    end else if (step) begin
      // arithmetic right shift of {sum, lower half}
      acc_q  <= {sum[WIDTH:1], sum[0], acc_q[WIDTH-1:1]};
      xbit_q <= acc_q[0];
    end
  end

  assign product = acc_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product)); // R6
  AST_MCAND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mc_q)); // R7
endmodule

// File: tb/sim_booth_seq_mult.sv
module sim_booth_seq_mult;
  localparam int WIDTH  = 8;
  localparam int PERIOD = 10;
  localparam int NV     = 10;

  localparam logic [7:0]  VA [NV] = '{8'h02, 8'h00, 8'h7F, 8'h80, 8'h80,
                                      8'hFF, 8'h55, 8'h07, 8'h80, 8'hFF};
  localparam logic [7:0]  VB [NV] = '{8'hFD, 8'h00, 8'h7F, 8'h80, 8'h7F,
                                      8'hFF, 8'hAA, 8'h05, 8'h01, 8'h7F};
  localparam logic [15:0] VP [NV] = '{16'hFFFA, 16'h0000, 16'h3F01, 16'h4000, 16'hC080,
                                      16'h0001, 16'hE372, 16'h0023, 16'hFF80, 16'hFF81};

  logic clk = 0, rst_n = 0, start = 0;
  logic [WIDTH-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [2*WIDTH-1:0] product;
  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  booth_seq_mult #(.WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // waits at negedges until done; returns number of negedges counted
  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic launch(input logic [7:0] a, input logic [7:0] b);
    mcand = a; mplier = b; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int cyc;
    logic [15:0] held;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, busy}, 0);
    check("R1", {31'd0, done}, 0);
    check("R1", {16'd0, product}, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 R5 table of vectors
    for (int i = 0; i < NV; i++) begin
      launch(VA[i], VB[i]);
      check("R2", {31'd0, busy}, 1);
      wait_done(cyc);
      check("R3", cyc, WIDTH);
      check("R8", {31'd0, busy}, 0);
      check((i == 3 || i == 4) ? "R5" : "R4", {16'd0, product}, {16'd0, VP[i]});
      check("R4 bench model", {16'd0, product},
            {16'd0, 16'($signed(VA[i]) * $signed(VB[i]))});
      @(negedge clk);
      check("R3", {31'd0, done}, 0);
    end

    // R6 product held while idle, operands wiggling
    held = product;
    for (int k = 0; k < 5; k++) begin
      mcand = 8'(k * 37); mplier = 8'(k * 91 + 3);
      @(negedge clk);
      check("R6", {16'd0, product}, {16'd0, held});
    end

    // R7 start during busy ignored
    launch(8'hF9, 8'h0B);          // -7 * 11 = -77
    repeat (2) @(negedge clk);
    mcand = 8'h33; mplier = 8'h44; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 3;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check("R7", cyc, WIDTH);
    check("R7", {16'd0, product}, {16'd0, 16'hFFB3});

    // start in the same cycle as done: accepted
    mcand = 8'h81; mplier = 8'h81; start = 1;   // -127 * -127 = 16129
    @(negedge clk);
    start = 0;
    check("R2", {31'd0, busy}, 1);
    wait_done(cyc);
    check("R3", cyc, WIDTH);
    check("R4", {16'd0, product}, {16'd0, 16'h3F01});

    // width-4 style example scaled: 2 * -3 again after back-to-back
    launch(8'h02, 8'hFD);
    wait_done(cyc);
    check("R4", {16'd0, product}, {16'd0, 16'hFFFA});

    finish_run();
  end
endmodule